// File: doc/BRIEF.md
# Sparse Rank-Order Baseline Estimator

This block estimates the slowly varying baseline under a stream of detector samples. Pulses riding on the baseline are outliers, so the block does not average. It keeps only every N-th accepted sample. The last eight retained samples are held in a window that stays sorted at all times. The estimate is then taken from that sorted window, in one of two ways. The first returns the sample at a programmed rank, such as the median. The second forms a weighted sum over the sorted samples using signed fixed-point weights, which covers trimmed means and similar operators.

Samples enter and results leave through valid/ready streams. An input sample moves on the cycle where `in_valid` and `in_ready` are both high. A result moves on the cycle where `out_valid` and `out_ready` are both high. Back-pressure works as follows. While a result is waiting with `out_ready` low, `out_valid` stays high and `out_data` holds its value, and `in_ready` is low. `in_ready` is also low for one cycle after a retained sample that leaves the window full, which is the cycle in which the result for that sample is formed. The configuration pins are plain levels and are held constant while samples are flowing.

Top module: `sparse_baseline`

## Requirements
- R1: While reset is applied and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: `cfg_ratio` holds the decimation factor minus one, so 0..15 selects a factor of 1..16. The first sample accepted after reset is retained, and after that every (`cfg_ratio`+1)-th accepted sample is retained.
- R3: No result is produced until eight samples have been retained since reset. The eighth retained sample produces the first result.
- R4: After the window is full, each retained sample produces exactly one result, in order. That result is computed over the eight most recently retained samples.
- R5: With `cfg_mode`=0, the result is the window sample at sorted position `cfg_rank`, where 0 is the smallest and 7 the largest.
- R6: With `cfg_mode`=1, the result is the sum over i of w_i times sorted sample i, where sorted sample 0 is the smallest. Weight w_i is `cfg_weights[8i+7:8i]`, a signed two's-complement value with 5 fraction bits. The sum is rounded by adding 16 and shifting right arithmetically by 5, and is then clamped to 0..4095.
- R7: On a constant baseline with isolated pulses, where no two pulses fall in the same window, median ranks 3 and 4 return the baseline value exactly.
- R8: An input is taken only when `in_valid` and `in_ready` are both high. `in_ready` is low whenever `out_valid` is high and `out_ready` is low. A waiting result keeps `out_valid` high and `out_data` unchanged until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_data | input | 12 | Unsigned input sample |
| out_valid | output | 1 | Baseline result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 12 | Baseline estimate |
| cfg_ratio | input | 4 | Decimation factor minus one |
| cfg_mode | input | 1 | 0: rank select, 1: weighted sorted sum |
| cfg_rank | input | 3 | Sorted position picked in rank mode |
| cfg_weights | input | 64 | Eight signed weights, weight i in bits [8i+7:8i] |

## Verification
The assertions assume that the source holds a stalled sample and the consumer lowers `out_ready` freely. They also assume that the configuration does not change while data is flowing, because a mid-stream change in rank or weights would make a result mix two settings. The stimulus keeps to this. It holds `in_data` while a sample waits for acceptance and randomizes both valid and ready each cycle. It changes `cfg_ratio`, `cfg_mode`, `cfg_rank` and `cfg_weights` only while reset is held between test phases.

// File: rtl/sbl_pkg.sv
package sbl_pkg;
  typedef enum logic {
    SEL_RANK  = 1'b0,
    SEL_LSUM  = 1'b1
  } sbl_sel_e;
endpackage

// File: rtl/sbl_decim.sv
module sbl_decim #(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [FW-1:0] ratio,
  output logic          keep
);
  logic [FW-1:0] ph_q;

  assign keep = take && (ph_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (take) begin
      ph_q <= (ph_q >= ratio) ? '0 : ph_q + 1'b1;
    end
  end
endmodule

// File: rtl/sbl_window.sv
module sbl_window #(
  parameter int DW  = 12,
  parameter int WIN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_val,
  output logic [DW-1:0] srt_val [WIN],
  output logic          upd
);
  localparam int AW = $clog2(WIN);
  localparam int CW = $clog2(WIN + 1);

  logic [DW-1:0]  val_q [WIN];
  logic [DW-1:0]  val_d [WIN];
  logic [AW-1:0]  age_q [WIN];
  logic [AW-1:0]  age_d [WIN];
  logic [WIN-1:0] vld_q, vld_d;
  logic [CW-1:0]  cnt_q;
  logic           upd_q;

  logic [DW-1:0]  c_val [WIN];
  logic [AW-1:0]  c_age [WIN];
  logic [WIN-1:0] c_vld;
  int             rm_i;
  int             ins_p;

  always_comb begin
    rm_i = WIN - 1;
    if (cnt_q == CW'(WIN)) begin
      for (int i = 0; i < WIN; i++) begin
        if (age_q[i] == AW'(WIN - 1)) rm_i = i;
      end
    end
    for (int j = 0; j < WIN; j++) begin
      int k;
      k = (j + 1 < WIN) ? j + 1 : j;
      if (j < rm_i) begin
        c_val[j] = val_q[j];
        c_age[j] = age_q[j];
        c_vld[j] = vld_q[j];
      end else begin
        c_val[j] = val_q[k];
        c_age[j] = age_q[k];
        c_vld[j] = vld_q[k] && (j + 1 < WIN);
      end
    end
    ins_p = 0;
    for (int j = 0; j < WIN; j++) begin
      if (c_vld[j] && (c_val[j] <= push_val)) ins_p = ins_p + 1;
    end
    for (int i = 0; i < WIN; i++) begin
      int k;
      k = (i == 0) ? 0 : i - 1;
      if (i < ins_p) begin
        val_d[i] = c_val[i];
        age_d[i] = c_age[i] + 1'b1;
        vld_d[i] = c_vld[i];
      end else if (i == ins_p) begin
        val_d[i] = push_val;
        age_d[i] = '0;
        vld_d[i] = 1'b1;
      end else begin
        val_d[i] = c_val[k];
        age_d[i] = c_age[k] + 1'b1;
        vld_d[i] = c_vld[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN; i++) begin
        val_q[i] <= '0;
        age_q[i] <= '0;
      end
      vld_q <= '0;
      cnt_q <= '0;
      upd_q <= 1'b0;
    end else begin
      upd_q <= push && (cnt_q >= CW'(WIN - 1));
      if (push) begin
        for (int i = 0; i < WIN; i++) begin
          val_q[i] <= val_d[i];
          age_q[i] <= age_d[i];
        end
        vld_q <= vld_d;
        if (cnt_q != CW'(WIN)) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < WIN; i++) srt_val[i] = val_q[i];
  end
  assign upd = upd_q;

  // R4: the held entries stay in ascending order, empty slots at the top
  for (genvar g = 0; g < WIN - 1; g++) begin : g_order
    a_r4_sorted: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_q[g] && vld_q[g+1]) |-> (val_q[g] <= val_q[g+1]));
    a_r4_packed: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_q[g] |-> !vld_q[g+1]);
  end

  a_r4_fill_count: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(cnt_q));

  a_r3_upd_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    upd_q |-> (cnt_q == CW'(WIN)));
endmodule

// File: rtl/sbl_reduce.sv
module sbl_reduce
  import sbl_pkg::*;
#(
  parameter int DW  = 12,
  parameter int WIN = 8,
  parameter int WB  = 8,
  parameter int WF  = 5
) (
  input  logic [DW-1:0]       srt_val [WIN],
  input  sbl_sel_e            sel,
  input  logic [$clog2(WIN)-1:0] rank,
  input  logic [WIN*WB-1:0]   weights,
  output logic [DW-1:0]       res
);
  localparam int SW = DW + WB + $clog2(WIN) + 2;
  localparam logic signed [SW-1:0] MAXV = SW'((1 << DW) - 1);
  localparam logic signed [SW-1:0] HALF = SW'(1 << (WF - 1));

  logic signed [SW-1:0] acc;
  logic signed [SW-1:0] scaled;
  logic [DW-1:0]        lsum;

  always_comb begin
    acc = '0;
    for (int i = 0; i < WIN; i++) begin
      acc = acc + SW'($signed({1'b0, srt_val[i]})) * SW'($signed(weights[i*WB +: WB]));
    end
    scaled = (acc + HALF) >>> WF;
    if (scaled < 0) lsum = '0;
    else if (scaled > MAXV) lsum = MAXV[DW-1:0];
    else lsum = scaled[DW-1:0];
  end

  assign res = (sel == SEL_LSUM) ? lsum : srt_val[rank];
endmodule

// File: rtl/sparse_baseline.sv
module sparse_baseline
  import sbl_pkg::*;
#(
  parameter int DW  = 12,
  parameter int WIN = 8,
  parameter int FW  = 4,
  parameter int WB  = 8,
  parameter int WF  = 5,
  localparam int AW = $clog2(WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DW-1:0]     in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  input  logic [FW-1:0]     cfg_ratio,
  input  logic              cfg_mode,
  input  logic [AW-1:0]     cfg_rank,
  input  logic [WIN*WB-1:0] cfg_weights
);
  logic          take;
  logic          keep;
  logic          upd;
  logic [DW-1:0] srt_val [WIN];
  logic [DW-1:0] res;
  sbl_sel_e      sel;

  assign sel      = sbl_sel_e'(cfg_mode);
  assign in_ready = !upd && !(out_valid && !out_ready);
  assign take     = in_valid && in_ready;

  sbl_decim #(.FW(FW)) u_decim (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (take),
    .ratio (cfg_ratio),
    .keep  (keep)
  );

  sbl_window #(.DW(DW), .WIN(WIN)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (keep),
    .push_val (in_data),
    .srt_val  (srt_val),
    .upd      (upd)
  );

  sbl_reduce #(.DW(DW), .WIN(WIN), .WB(WB), .WF(WF)) u_reduce (
    .srt_val (srt_val),
    .sel     (sel),
    .rank    (cfg_rank),
    .weights (cfg_weights),
    .res     (res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (upd) begin
      out_valid <= 1'b1;
      out_data  <= res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r8_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/sparse_baseline_test.sv
module sparse_baseline_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [11:0] out_data;
  logic [3:0]  cfg_ratio = '0;
  logic        cfg_mode = 1'b0;
  logic [2:0]  cfg_rank = '0;
  logic [63:0] cfg_weights = '0;

  int n_checks = 0;
  int n_fail = 0;

  int win_m [8];
  int n_ret;
  int ph_m;
  int exp_q [$];
  int gen_i;

  always #(CLK_PERIOD/2) clk = ~clk;

  sparse_baseline uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .cfg_ratio(cfg_ratio), .cfg_mode(cfg_mode),
    .cfg_rank(cfg_rank), .cfg_weights(cfg_weights)
  );

  task automatic check(input string req, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int model_out();
    int s [8];
    int t;
    int acc;
    for (int i = 0; i < 8; i++) s[i] = win_m[i];
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 7 - i; j++)
        if (s[j] > s[j+1]) begin t = s[j]; s[j] = s[j+1]; s[j+1] = t; end
    if (cfg_mode == 1'b0) return s[cfg_rank];
    acc = 0;
    for (int i = 0; i < 8; i++) acc += s[i] * int'($signed(cfg_weights[i*8 +: 8]));
    acc = (acc + 16) >>> 5;
    if (acc < 0) acc = 0;
    if (acc > 4095) acc = 4095;
    return acc;
  endfunction

  // R2, R3, R4: bench-side decimation and window bookkeeping
  task automatic model_accept(input int v);
    if (ph_m == 0) begin
      for (int i = 7; i > 0; i--) win_m[i] = win_m[i-1];
      win_m[0] = v;
      n_ret++;
      if (n_ret >= 8) exp_q.push_back(model_out());
    end
    ph_m = (ph_m >= int'(cfg_ratio)) ? 0 : ph_m + 1;
  endtask

  function automatic logic [11:0] gen(input int style);
    int v;
    gen_i++;
    case (style)
      1: v = (gen_i % 10 == 0) ? 4000 : 1000;
      2: v = 4095;
      default: begin
        v = 800 + int'($urandom % 40);
        if ($urandom % 12 == 0) v += 1500 + int'($urandom % 1500);
        if (v > 4095) v = 4095;
      end
    endcase
    return 12'(v);
  endfunction

  task automatic run_phase(input int cycles, input logic [3:0] ratio,
                           input logic mode, input logic [2:0] rank,
                           input logic [63:0] w, input int style,
                           input int vprob, input int rprob, input string req);
    logic hold_pend;
    logic [11:0] held;
    logic acc_now;
    in_valid = 1'b0;
    out_ready = 1'b0;
    rst_n = 1'b0;
    cfg_ratio = ratio; cfg_mode = mode; cfg_rank = rank; cfg_weights = w;
    for (int i = 0; i < 8; i++) win_m[i] = 0;
    n_ret = 0; ph_m = 0; gen_i = 0;
    exp_q.delete();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    hold_pend = 1'b0;
    held = '0;
    for (int c = 0; c < cycles + 12; c++) begin
      @(negedge clk);
      if (hold_pend) begin
        check("R8 hold valid", int'(out_valid), 1);
        check("R8 hold data", int'(out_data), int'(held));
      end
      if (out_valid && !out_ready) check("R8 stall blocks input", int'(in_ready), 0);
      acc_now = in_valid && in_ready;
      if (acc_now) model_accept(int'(in_data));
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check({req, " unexpected result (R3)"}, int'(out_data), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          check(req, int'(out_data), e);
          if (style == 1 && (rank == 3'd3 || rank == 3'd4) && mode == 1'b0)
            check("R7 pulse immunity", int'(out_data), 1000);
        end
      end
      hold_pend = out_valid && !out_ready;
      held = out_data;
      @(posedge clk);
      #1;
      if (c >= cycles) begin
        in_valid = 1'b0;
        out_ready = 1'b1;
      end else begin
        if (!in_valid || acc_now) begin
          in_valid = ($urandom % 100) < vprob;
          if (in_valid) in_data = gen(style);
        end
        out_ready = ($urandom % 100) < rprob;
      end
    end
    check({req, " all results delivered (R4)"}, exp_q.size(), 0);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    join_none
  end

  initial begin
    logic [63:0] w;
    void'($urandom(32'd4711));
    // R1: reset state
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 in_ready in reset", int'(in_ready), 1);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);

    // R5: median on noisy data with pulses, no decimation
    run_phase(300, 4'd0, 1'b0, 3'd3, 64'd0, 0, 80, 90, "R5 rank median");
    // R7: isolated pulses on a flat baseline
    run_phase(200, 4'd0, 1'b0, 3'd4, 64'd0, 1, 100, 100, "R7 flat baseline");
    run_phase(200, 4'd0, 1'b0, 3'd3, 64'd0, 1, 70, 60, "R7 flat baseline");
    // R2: largest decimation, maximum rank
    run_phase(1500, 4'd15, 1'b0, 3'd7, 64'd0, 0, 90, 80, "R2 ratio 16 rank 7");
    // R8: heavy back-pressure, smallest rank, factor 2
    run_phase(600, 4'd1, 1'b0, 3'd0, 64'd0, 0, 90, 25, "R8 rank 0 stalls");
    // R6: trimmed mean weights, factor 4
    w = {8'd0, 8'd0, 8'd8, 8'd8, 8'd8, 8'd8, 8'd0, 8'd0};
    run_phase(600, 4'd3, 1'b1, 3'd0, w, 0, 85, 85, "R6 trimmed mean");
    // R6: random signed weights
    for (int p = 0; p < 3; p++) begin
      w = {$urandom, $urandom};
      run_phase(300, 4'(p), 1'b1, 3'd0, w, 0, 85, 70, "R6 random weights");
    end
    // R6: saturation at both ends
    run_phase(120, 4'd0, 1'b1, 3'd0, {8{8'h7f}}, 2, 100, 100, "R6 clamp high");
    run_phase(120, 4'd0, 1'b1, 3'd0, {8{8'h80}}, 2, 100, 100, "R6 clamp low");
    // R3: exactly seven retained samples give no result
    run_phase(7, 4'd0, 1'b0, 3'd3, 64'd0, 0, 100, 100, "R3 seven samples");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule